// File: doc/BRIEF.md
# Palette DAC Host Register Block

This block is the host-facing register file of a palette DAC. The host reaches it over an 8-bit bus with a 4-bit register offset. The block holds the command bytes, the pixel mask and the hardware-cursor position. It gathers palette and cursor-colour writes, which arrive as streams of red, green and blue bytes. Each completed colour leaves the block as a single write strobe that carries the entry index and a 24-bit colour, ready for the palette RAM or the cursor colour store. The host can read back every register it can write, except the two colour data ports.

A fourth command byte has no offset of its own. It appears in place of the read-only status byte only when two conditions hold together: the extended-access bit of command 0 is set, and the palette write-address register holds index 1. The palette address steps forward after each complete colour, so a run of consecutive entries needs only one index write. Command 0 bit 1 selects 8-bit colour components. When that bit is clear, each component keeps only its low six bits.

Top module: `pdac_host_regs`

## Requirements
- R1: A write with bus_sel=1, bus_wr=1 at offset n updates only the register at n. The offsets are: 0 palette write address, 1 palette data, 2 pixel mask, 3 palette read address, 4 cursor-colour write address, 5 cursor-colour data, 6 command 0, 7 cursor-colour read address, 8 command 1, 9 command 2, A status/command 3, B cursor bitmap data, C/D cursor X low/high, E/F cursor Y low/high. bus_rdata is combinational from bus_addr and returns the stored value. Offsets 1, 5 and B read as 0x00, and a write to B is ignored.
- R2: After reset, every register reads 0x00 except the pixel mask, which reads 0xFF. Offset A reads status_in.
- R3: Command 3 is written and read at offset A only while command 0 bit 7 is 1 and the palette write address is 0x01. In that case offset A reads command 3 and cfg_cmd3 follows the written byte.
- R4: The third of three data writes at offset 1 makes pal_we high for exactly one cycle after the write edge. That pulse carries pal_index equal to the write address and pal_rgb equal to {first, second, third}.
- R5: Each completed palette triplet increments the write address by one, and 0xFF wraps to 0x00.
- R6: A write to offset 0 or offset 3 sends the palette byte counter back to red. A write to offset 4 or offset 7 does the same for the cursor-colour byte counter.
- R7: Offset 4 loads the cursor-colour index from bits 1:0. Every three bytes at offset 5 produce one cur_col_we pulse with that index and {r,g,b}. The index then advances through 0,1,2,3 and wraps to 0.
- R8: Cursor X and Y are 12 bits wide. The low byte at offset C/E sets bits 7:0. Bits 3:0 of the byte at offset D/F set bits 11:8 and its bits 7:4 are ignored, so offsets D/F read back with the upper nibble zero.
- R9: While command 0 bit 1 is 0, every captured colour byte is reduced to its low six bits with bits 7:6 zero. While it is 1, all eight bits pass. dac_8bit equals command 0 bit 1.
- R10: When the gating of R3 is not met, offset A reads status_in, and a write there leaves command 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Readback data for bus_addr |
| status_in | input | 8 | Read-only status byte |
| cfg_cmd0 | output | 8 | Command 0 |
| cfg_cmd1 | output | 8 | Command 1 |
| cfg_cmd2 | output | 8 | Command 2 |
| cfg_cmd3 | output | 8 | Command 3 (indirect) |
| pix_mask | output | 8 | Pixel mask |
| dac_8bit | output | 1 | 8-bit component mode |
| cur_x | output | 12 | Cursor X position |
| cur_y | output | 12 | Cursor Y position |
| pal_we | output | 1 | Palette entry write strobe |
| pal_index | output | 8 | Palette entry index |
| pal_rgb | output | 24 | Palette colour {r,g,b} |
| cur_col_we | output | 1 | Cursor colour write strobe |
| cur_col_index | output | 2 | Cursor colour index |
| cur_col_rgb | output | 24 | Cursor colour {r,g,b} |

## Verification
The assertions check four things on every cycle. At most one register is hit per access. Command 3 changes only after a gated write at offset A. The high cursor nibble changes only after a write to its own offset. Each colour strobe is a single-cycle pulse that leaves the write address one past the index it carried. Only the bench scenarios can show the values themselves. These include the RGB packing and six-bit narrowing, the address wrap, the counter restart after a mid-triplet address write, and the flip between status and command 3 at offset A as the index and the extended bit change. The bench shows them by comparing every strobe against a queue of expected entries and by reading registers back.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int DW = 8;
  localparam int NREG = 16;

  localparam logic [3:0] OFS_WADDR  = 4'h0;
  localparam logic [3:0] OFS_PDATA  = 4'h1;
  localparam logic [3:0] OFS_PMASK  = 4'h2;
  localparam logic [3:0] OFS_RADDR  = 4'h3;
  localparam logic [3:0] OFS_CWADDR = 4'h4;
  localparam logic [3:0] OFS_CDATA  = 4'h5;
  localparam logic [3:0] OFS_CMD0   = 4'h6;
  localparam logic [3:0] OFS_CRADDR = 4'h7;
  localparam logic [3:0] OFS_CMD1   = 4'h8;
  localparam logic [3:0] OFS_CMD2   = 4'h9;
  localparam logic [3:0] OFS_STAT   = 4'hA;
  localparam logic [3:0] OFS_CRAM   = 4'hB;
  localparam logic [3:0] OFS_XLO    = 4'hC;
  localparam logic [3:0] OFS_XHI    = 4'hD;
  localparam logic [3:0] OFS_YLO    = 4'hE;
  localparam logic [3:0] OFS_YHI    = 4'hF;

  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GRN = 2'd1, PH_BLU = 2'd2} phase_e;

  // Component narrowing for the six-bit DAC mode.
  function automatic logic [DW-1:0] dac_narrow(input logic [DW-1:0] d, input logic wide);
    return wide ? d : {2'b00, d[DW-3:0]};
  endfunction

  // Indirect command register visible when extended access is on and index is 1.
  function automatic logic ind_gate(input logic ext_bit, input logic [DW-1:0] idx);
    return ext_bit && (idx == DW'(1));
  endfunction
endpackage

// File: rtl/pdac_decode.sv
module pdac_decode
  import pdac_pkg::*;
(
  input  logic            sel,
  input  logic            wr,
  input  logic [3:0]      addr,
  output logic [NREG-1:0] wr_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign wr_hit[i] = sel && wr && (addr == 4'(i));
  end
endmodule

// File: rtl/pdac_cfg_regs.sv
module pdac_cfg_regs
  import pdac_pkg::*;
#(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREG-1:0]  wr_hit,
  input  logic [DW-1:0]    wdata,
  input  logic             cmd3_en,
  output logic [DW-1:0]    cmd0_o,
  output logic [DW-1:0]    cmd1_o,
  output logic [DW-1:0]    cmd2_o,
  output logic [DW-1:0]    cmd3_o,
  output logic [DW-1:0]    pmask_o,
  output logic [DW-1:0]    raddr_o,
  output logic [DW-1:0]    craddr_o,
  output logic [POS_W-1:0] cur_x_o,
  output logic [POS_W-1:0] cur_y_o
);
  localparam int HI_W = POS_W - DW;

  logic cmd3_write;
  assign cmd3_write = wr_hit[OFS_STAT] && cmd3_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd0_o   <= '0;
      cmd1_o   <= '0;
      cmd2_o   <= '0;
      cmd3_o   <= '0;
      pmask_o  <= '1;
      raddr_o  <= '0;
      craddr_o <= '0;
      cur_x_o  <= '0;
      cur_y_o  <= '0;
    end else begin
      if (wr_hit[OFS_CMD0])   cmd0_o   <= wdata;
      if (wr_hit[OFS_CMD1])   cmd1_o   <= wdata;
      if (wr_hit[OFS_CMD2])   cmd2_o   <= wdata;
      if (cmd3_write)         cmd3_o   <= wdata;
      if (wr_hit[OFS_PMASK])  pmask_o  <= wdata;
      if (wr_hit[OFS_RADDR])  raddr_o  <= wdata;
      if (wr_hit[OFS_CRADDR]) craddr_o <= wdata;
      if (wr_hit[OFS_XLO])    cur_x_o[DW-1:0]      <= wdata;
      if (wr_hit[OFS_XHI])    cur_x_o[POS_W-1:DW]  <= wdata[HI_W-1:0];
      if (wr_hit[OFS_YLO])    cur_y_o[DW-1:0]      <= wdata;
      if (wr_hit[OFS_YHI])    cur_y_o[POS_W-1:DW]  <= wdata[HI_W-1:0];
    end
  end

  p_decode_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit));

  p_cmd3_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd3_o) |-> $past(wr_hit[OFS_STAT] && cmd3_en));

  p_xhi_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_x_o[POS_W-1:DW]) |-> $past(wr_hit[OFS_XHI]));
endmodule

// File: rtl/pdac_triplet_seq.sv
module pdac_triplet_seq
  import pdac_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_addr,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              clr_phase,
  input  logic              data_wr,
  input  logic [DW-1:0]     data_in,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [3*DW-1:0]   rgb_o
);
  phase_e        phase_q;
  logic [DW-1:0] red_q, grn_q;
  logic          triplet_done;

  assign triplet_done = data_wr && !load_addr && !clr_phase && (phase_q == PH_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_RED;
      red_q     <= '0;
      grn_q     <= '0;
      addr_o    <= '0;
      we_o      <= 1'b0;
      wr_addr_o <= '0;
      rgb_o     <= '0;
    end else begin
      we_o <= triplet_done;
      if (load_addr) begin
        addr_o  <= load_val;
        phase_q <= PH_RED;
      end else if (clr_phase) begin
        phase_q <= PH_RED;
      end else if (data_wr) begin
        unique case (phase_q)
          PH_RED: begin red_q <= data_in; phase_q <= PH_GRN; end
          PH_GRN: begin grn_q <= data_in; phase_q <= PH_BLU; end
          default: begin
            wr_addr_o <= addr_o;
            rgb_o     <= {red_q, grn_q, data_in};
            addr_o    <= addr_o + 1'b1;
            phase_q   <= PH_RED;
          end
        endcase
      end
    end
  end

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> !we_o);

  p_post_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> (addr_o == ADDR_W'(wr_addr_o + 1'b1)));
endmodule

// File: rtl/pdac_host_regs.sv
module pdac_host_regs
  import pdac_pkg::*;
#(
  parameter int PAL_AW = 8,
  parameter int CUR_AW = 2,
  parameter int POS_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        status_in,
  output logic [7:0]        cfg_cmd0,
  output logic [7:0]        cfg_cmd1,
  output logic [7:0]        cfg_cmd2,
  output logic [7:0]        cfg_cmd3,
  output logic [7:0]        pix_mask,
  output logic              dac_8bit,
  output logic [POS_W-1:0]  cur_x,
  output logic [POS_W-1:0]  cur_y,
  output logic              pal_we,
  output logic [PAL_AW-1:0] pal_index,
  output logic [23:0]       pal_rgb,
  output logic              cur_col_we,
  output logic [CUR_AW-1:0] cur_col_index,
  output logic [23:0]       cur_col_rgb
);
  logic [NREG-1:0]   wr_hit;
  logic [DW-1:0]     pal_raddr, cur_raddr;
  logic [PAL_AW-1:0] pal_waddr;
  logic [CUR_AW-1:0] cur_waddr;
  logic [DW-1:0]     comp_byte;
  logic              cmd3_en;

  pdac_decode u_decode (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wr_hit(wr_hit)
  );

  assign cmd3_en   = ind_gate(cfg_cmd0[7], DW'(pal_waddr));
  assign dac_8bit  = cfg_cmd0[1];
  assign comp_byte = dac_narrow(bus_wdata, dac_8bit);

  pdac_cfg_regs #(.POS_W(POS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wdata(bus_wdata),
    .cmd3_en(cmd3_en),
    .cmd0_o(cfg_cmd0), .cmd1_o(cfg_cmd1), .cmd2_o(cfg_cmd2), .cmd3_o(cfg_cmd3),
    .pmask_o(pix_mask), .raddr_o(pal_raddr), .craddr_o(cur_raddr),
    .cur_x_o(cur_x), .cur_y_o(cur_y)
  );

  pdac_triplet_seq #(.ADDR_W(PAL_AW)) u_pal_seq (
    .clk(clk), .rst_n(rst_n),
    .load_addr(wr_hit[OFS_WADDR]), .load_val(bus_wdata[PAL_AW-1:0]),
    .clr_phase(wr_hit[OFS_RADDR]),
    .data_wr(wr_hit[OFS_PDATA]), .data_in(comp_byte),
    .addr_o(pal_waddr), .we_o(pal_we), .wr_addr_o(pal_index), .rgb_o(pal_rgb)
  );

  pdac_triplet_seq #(.ADDR_W(CUR_AW)) u_cur_seq (
    .clk(clk), .rst_n(rst_n),
    .load_addr(wr_hit[OFS_CWADDR]), .load_val(bus_wdata[CUR_AW-1:0]),
    .clr_phase(wr_hit[OFS_CRADDR]),
    .data_wr(wr_hit[OFS_CDATA]), .data_in(comp_byte),
    .addr_o(cur_waddr), .we_o(cur_col_we), .wr_addr_o(cur_col_index), .rgb_o(cur_col_rgb)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_WADDR:  bus_rdata = DW'(pal_waddr);
      OFS_PMASK:  bus_rdata = pix_mask;
      OFS_RADDR:  bus_rdata = pal_raddr;
      OFS_CWADDR: bus_rdata = DW'(cur_waddr);
      OFS_CMD0:   bus_rdata = cfg_cmd0;
      OFS_CRADDR: bus_rdata = cur_raddr;
      OFS_CMD1:   bus_rdata = cfg_cmd1;
      OFS_CMD2:   bus_rdata = cfg_cmd2;
      OFS_STAT:   bus_rdata = cmd3_en ? cfg_cmd3 : status_in;
      OFS_XLO:    bus_rdata = cur_x[DW-1:0];
      OFS_XHI:    bus_rdata = DW'(cur_x[POS_W-1:DW]);
      OFS_YLO:    bus_rdata = cur_y[DW-1:0];
      OFS_YHI:    bus_rdata = DW'(cur_y[POS_W-1:DW]);
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/pdac_host_regs_tb.sv
`timescale 1ns/1ps
module pdac_host_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] status_in = 8'h5A;
  logic [7:0] cfg_cmd0, cfg_cmd1, cfg_cmd2, cfg_cmd3, pix_mask;
  logic dac_8bit;
  logic [11:0] cur_x, cur_y;
  logic pal_we, cur_col_we;
  logic [7:0] pal_index;
  logic [1:0] cur_col_index;
  logic [23:0] pal_rgb, cur_col_rgb;

  always #2.5 clk = ~clk;

  pdac_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .status_in(status_in), .cfg_cmd0(cfg_cmd0), .cfg_cmd1(cfg_cmd1),
    .cfg_cmd2(cfg_cmd2), .cfg_cmd3(cfg_cmd3), .pix_mask(pix_mask),
    .dac_8bit(dac_8bit), .cur_x(cur_x), .cur_y(cur_y),
    .pal_we(pal_we), .pal_index(pal_index), .pal_rgb(pal_rgb),
    .cur_col_we(cur_col_we), .cur_col_index(cur_col_index), .cur_col_rgb(cur_col_rgb)
  );

  typedef struct packed {
    logic        is_cur;
    logic [7:0]  idx;
    logic [23:0] rgb;
    logic [3:0]  req;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic wide = 1'b0;
  logic [7:0] exp_pidx = '0;
  logic [1:0] exp_cidx = '0;

  function automatic logic [7:0] nar(input logic [7:0] v);
    return wide ? v : (v & 8'h3F);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, 32'(bus_rdata), 32'(exp));
    bus_sel = 1'b0;
  endtask

  task automatic pal_entry(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    item_t it;
    wr(4'h1, r); wr(4'h1, g);
    it.is_cur = 1'b0; it.idx = exp_pidx; it.rgb = {nar(r), nar(g), nar(b)}; it.req = 4'd4;
    exp_q.push_back(it);
    wr(4'h1, b);
    exp_pidx = exp_pidx + 1'b1;
  endtask

  task automatic cur_entry(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    item_t it;
    wr(4'h5, r); wr(4'h5, g);
    it.is_cur = 1'b1; it.idx = 8'(exp_cidx); it.rgb = {nar(r), nar(g), nar(b)}; it.req = 4'd7;
    exp_q.push_back(it);
    wr(4'h5, b);
    exp_cidx = exp_cidx + 1'b1;
  endtask

  // Monitor: every strobe pops one expected entry (R4, R7).
  always @(negedge clk) begin
    if (rst_n && (pal_we || cur_col_we)) begin
      item_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R7 unexpected strobe actual pal=%0b cur=%0b expected none", pal_we, cur_col_we);
      end else begin
        e = exp_q.pop_front();
        if (e.is_cur != cur_col_we || e.is_cur == pal_we ||
            (!e.is_cur && (pal_index != e.idx || pal_rgb != e.rgb)) ||
            (e.is_cur && (8'(cur_col_index) != e.idx || cur_col_rgb != e.rgb))) begin
          errors++;
          $display("FAIL R%0d strobe actual idx=%0h/%0h rgb=%0h/%0h expected cur=%0b idx=%0h rgb=%0h",
                   e.req, pal_index, cur_col_index, pal_rgb, cur_col_rgb, e.is_cur, e.idx, e.rgb);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset values
    rd(4'h0, 8'h00, "R2 waddr");
    rd(4'h2, 8'hFF, "R2 pixmask");
    rd(4'h6, 8'h00, "R2 cmd0");
    rd(4'hA, 8'h5A, "R2 status");
    rd(4'hD, 8'h00, "R2 xhi");
    check("R2 cmd3 port", 32'(cfg_cmd3), 32'h0);

    // R9 eight-bit mode and R4/R5 streaming
    wr(4'h6, 8'h02); wide = 1'b1;
    check("R9 dac_8bit", 32'(dac_8bit), 32'h1);
    wr(4'h0, 8'h10); exp_pidx = 8'h10;
    pal_entry(8'hC1, 8'hD2, 8'hE3);
    pal_entry(8'h11, 8'h22, 8'h33);
    pal_entry(8'hFF, 8'h00, 8'h80);
    rd(4'h0, 8'h13, "R5 waddr after three entries");

    // R5 wrap
    wr(4'h0, 8'hFF); exp_pidx = 8'hFF;
    pal_entry(8'h01, 8'h02, 8'h03);
    rd(4'h0, 8'h00, "R5 wrap");

    // R6 phase reset by read address and by write address
    wr(4'h0, 8'h05); exp_pidx = 8'h05;
    wr(4'h1, 8'hAA); wr(4'h1, 8'hBB);
    wr(4'h3, 8'h77);
    rd(4'h3, 8'h77, "R1 raddr readback");
    pal_entry(8'h44, 8'h55, 8'h66);
    wr(4'h1, 8'h99);
    wr(4'h0, 8'h20); exp_pidx = 8'h20;
    pal_entry(8'h12, 8'h34, 8'h56);

    // R9 six-bit mode
    wr(4'h6, 8'h00); wide = 1'b0;
    check("R9 dac_8bit clear", 32'(dac_8bit), 32'h0);
    pal_entry(8'hFF, 8'hC3, 8'h81);

    // R3 / R10 indirect command register
    wr(4'h6, 8'h02); wide = 1'b1;
    wr(4'h0, 8'h01);
    wr(4'hA, 8'h0C);
    check("R10 write ignored without ext", 32'(cfg_cmd3), 32'h0);
    rd(4'hA, 8'h5A, "R10 status without ext");
    wr(4'h6, 8'h82);
    wr(4'hA, 8'h0C);
    check("R3 cmd3 written", 32'(cfg_cmd3), 32'h0C);
    rd(4'hA, 8'h0C, "R3 cmd3 readback");
    wr(4'h0, 8'h02);
    rd(4'hA, 8'h5A, "R10 status with wrong index");
    wr(4'hA, 8'h33);
    check("R10 cmd3 kept on wrong index", 32'(cfg_cmd3), 32'h0C);
    wr(4'h6, 8'h02);
    status_in = 8'hA7;
    rd(4'hA, 8'hA7, "R10 status follows input");

    // R7 cursor colours with wrap, R6 cursor phase reset
    wr(4'h4, 8'h00); exp_cidx = 2'd0;
    cur_entry(8'h00, 8'h00, 8'h00);
    cur_entry(8'h10, 8'h20, 8'h30);
    cur_entry(8'h10, 8'h20, 8'h30);
    cur_entry(8'hF0, 8'hE0, 8'hD0);
    cur_entry(8'h01, 8'h02, 8'h03);
    rd(4'h4, 8'h01, "R7 cursor index after wrap");
    wr(4'h5, 8'h55);
    wr(4'h7, 8'h00);
    cur_entry(8'h0A, 8'h0B, 8'h0C);
    wr(4'h4, 8'hFE); exp_cidx = 2'd2;
    cur_entry(8'h21, 8'h22, 8'h23);

    // R8 cursor position
    wr(4'hC, 8'h34); wr(4'hD, 8'hF7);
    check("R8 cur_x", 32'(cur_x), 32'h734);
    rd(4'hD, 8'h07, "R8 xhi readback");
    wr(4'hE, 8'h9A); wr(4'hF, 8'h5B);
    check("R8 cur_y", 32'(cur_y), 32'hB9A);
    rd(4'hE, 8'h9A, "R8 ylo readback");

    // R1 remaining registers
    wr(4'h2, 8'h3C); rd(4'h2, 8'h3C, "R1 pixmask");
    wr(4'h8, 8'h40); rd(4'h8, 8'h40, "R1 cmd1");
    wr(4'h9, 8'h23); rd(4'h9, 8'h23, "R1 cmd2");
    wr(4'hB, 8'hEE); rd(4'hB, 8'h00, "R1 cursor bitmap port reads zero");
    check("R1 cmd1 untouched by B", 32'(cfg_cmd1), 32'h40);
    rd(4'h1, 8'h00, "R1 palette data reads zero");
    rd(4'h6, 8'h02, "R1 cmd0");

    repeat (4) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule